// File: doc/BRIEF.md
# Byte-Serial Register Write Decoder

This block turns a narrow command stream into register writes. A host sends one byte per clock on an 8-bit bus. A strobe marks the first byte of each command. The block collects a 16-bit register address, low byte first, and then the data bytes. It checks the address against a base and a mask, both set by parameters. For a matching command it presents the assembled data word and the low relative address bits, together with a write enable that lasts one clock.

A command takes NUM_BYTES byte cycles in total. The default of 6 carries four data bytes, so the data word is 32 bits wide. The block uses a single clock and an active-low asynchronous reset. A sequencer decides what to do with each byte. A datapath stores the address, assembles the word and makes the match decision.

Top module: `byte_cmd_decoder`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises, regWrite is 0, regData is 0 and regAddr is 0. Any command that was partly collected is dropped, and no write comes from it.
- R2: Data bytes are packed little-endian. The first data byte (third byte of the command) goes into regData[7:0], and the last data byte goes into regData[31:24].
- R3: The address is the first byte, which is the low half, with the second byte as the high half. A command matches when (address & ADDR_MASK) == (BASE_ADDR & ADDR_MASK). With the defaults 0x300 and 0x3FE, addresses 0x300, 0x301, 0x700 and 0x1301 match, while 0x302, 0x200 and 0x3FF do not.
- R4: Take the clock edge that samples the last byte of a matching command. regWrite is 1 for the whole cycle after that edge, and for that cycle only.
- R5: A command that does not match gives no write. regData and regAddr keep their previous values.
- R6: On a write, regAddr carries the low REL_BITS bits of the command address. With the default REL_BITS=1, this is address bit 0. regAddr changes only together with a write.
- R7: A strobe arriving while a command is still being collected drops that command. The strobed byte starts a new command as its address-low byte.
- R8: Bytes that arrive without a strobe while no command is being collected are ignored.
- R9: A new command may strobe its first byte in the cycle right after the last byte of the previous command. Both commands then produce their writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdByte | input | 8 | Command byte, one per clock |
| cmdStrobe | input | 1 | Marks the address-low byte of a command |
| regAddr | output | REL_BITS | Relative register address of the last write |
| regData | output | 8*(NUM_BYTES-2) | Assembled data word of the last write |
| regWrite | output | 1 | One-clock write enable |

## Verification
A strobe is sampled at a clock edge E0. The edge that samples the final byte is E0+NUM_BYTES-1, which is E5 by default. The write result is registered at that edge, so regWrite, regData and regAddr first show it in the cycle after E5. The bench drives every byte on a falling edge. It reads the result on the falling edge that follows E5, and it checks one falling edge later that regWrite has dropped again. A monitor counts regWrite pulses on falling edges. Restart, idle-byte and back-to-back cases are judged by that count and by the held output values, so no single-cycle sample is needed for them.

// File: rtl/byte_cmd_pkg.sv
package byte_cmd_pkg;

  // Per-byte actions that the sequencer sends to the datapath
  typedef struct packed {
    logic takeLo;    // byte is the low address half
    logic takeHi;    // byte is the high address half
    logic shiftData; // byte is a data byte other than the last one
    logic commit;    // byte is the last data byte
  } byteCtrl_t;

  function automatic logic addrHit(input logic [15:0] addr,
                                   input logic [15:0] base,
                                   input logic [15:0] mask);
    return (addr & mask) == (base & mask);
  endfunction

endpackage

// File: rtl/byte_cmd_seq.sv
module byte_cmd_seq
  import byte_cmd_pkg::*;
#(
  parameter int NUM_BYTES = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStrobe,
  output byteCtrl_t ctrl
);
  localparam int CW = $clog2(NUM_BYTES);
  localparam logic [CW-1:0] LAST = CW'(NUM_BYTES - 1);

  logic          busy;
  logic [CW-1:0] idx;  // index of the byte expected next

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (cmdStrobe) begin
      busy <= 1'b1;
      idx  <= CW'(1);
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + CW'(1);
      end
    end
  end

  always_comb begin
    ctrl.takeLo    = cmdStrobe;
    ctrl.takeHi    = !cmdStrobe && busy && (idx == CW'(1));
    ctrl.shiftData = !cmdStrobe && busy && (idx >= CW'(2)) && (idx != LAST);
    ctrl.commit    = !cmdStrobe && busy && (idx == LAST);
  end

endmodule

// File: rtl/byte_cmd_path.sv
module byte_cmd_path
  import byte_cmd_pkg::*;
#(
  parameter int          NUM_BYTES = 6,
  parameter logic [15:0] BASE_ADDR = 16'h0300,
  parameter logic [15:0] ADDR_MASK = 16'h03FE,
  parameter int          REL_BITS  = 1,
  localparam int         DW        = 8 * (NUM_BYTES - 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          cmdByte,
  input  byteCtrl_t           ctrl,
  output logic [REL_BITS-1:0] regAddr,
  output logic [DW-1:0]       regData,
  output logic                regWrite
);
  localparam int AW = DW - 8;  // data bytes held before the last one

  logic [7:0]          addrLo;
  logic                hitReg;
  logic [REL_BITS-1:0] relReg;
  logic [AW-1:0]       acc;
  logic [DW-1:0]       wordNext;
  logic [15:0]         fullAddr;

  assign fullAddr = {cmdByte, addrLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0;
      hitReg <= 1'b0;
      relReg <= '0;
    end else if (ctrl.takeLo) begin
      addrLo <= cmdByte;
      hitReg <= 1'b0;
    end else if (ctrl.takeHi) begin
      hitReg <= addrHit(fullAddr, BASE_ADDR, ADDR_MASK);
      relReg <= fullAddr[REL_BITS-1:0];
    end
  end

  // Little-endian packing: a new byte enters at the top and moves down
  generate
    if (AW == 8) begin : g_oneHeld
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               acc <= '0;
        else if (ctrl.shiftData) acc <= cmdByte;
      end
    end else begin : g_shiftHeld
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               acc <= '0;
        else if (ctrl.shiftData) acc <= {cmdByte, acc[AW-1:8]};
      end
    end
  endgenerate

  assign wordNext = {cmdByte, acc};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regData  <= '0;
      regAddr  <= '0;
      regWrite <= 1'b0;
    end else begin
      regWrite <= ctrl.commit && hitReg;
      if (ctrl.commit && hitReg) begin
        regData <= wordNext;
        regAddr <= relReg;
      end
    end
  end

endmodule

// File: rtl/byte_cmd_decoder.sv
module byte_cmd_decoder
  import byte_cmd_pkg::*;
#(
  parameter int          NUM_BYTES = 6,        // 4..6 byte cycles per command
  parameter logic [15:0] BASE_ADDR = 16'h0300,
  parameter logic [15:0] ADDR_MASK = 16'h03FE,
  parameter int          REL_BITS  = 1,
  localparam int         DW        = 8 * (NUM_BYTES - 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          cmdByte,
  input  logic                cmdStrobe,
  output logic [REL_BITS-1:0] regAddr,
  output logic [DW-1:0]       regData,
  output logic                regWrite
);
  byteCtrl_t ctrl;

  byte_cmd_seq #(.NUM_BYTES(NUM_BYTES)) i_seq (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStrobe (cmdStrobe),
    .ctrl      (ctrl)
  );

  byte_cmd_path #(
    .NUM_BYTES (NUM_BYTES),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_MASK (ADDR_MASK),
    .REL_BITS  (REL_BITS)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .cmdByte  (cmdByte),
    .ctrl     (ctrl),
    .regAddr  (regAddr),
    .regData  (regData),
    .regWrite (regWrite)
  );

endmodule

// File: rtl/byte_cmd_decoder_chk.sv
module byte_cmd_decoder_chk #(
  parameter int NUM_BYTES = 6,
  parameter int REL_BITS  = 1,
  parameter int DW        = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdStrobe,
  input logic                regWrite,
  input logic [DW-1:0]       regData,
  input logic [REL_BITS-1:0] regAddr
);
  localparam int SW = $clog2(NUM_BYTES) + 1;

  // Clock cycles since the most recent strobe, saturating at NUM_BYTES
  logic [SW-1:0] sinceStb;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sinceStb <= SW'(NUM_BYTES);
    else if (cmdStrobe)                 sinceStb <= '0;
    else if (sinceStb != SW'(NUM_BYTES)) sinceStb <= sinceStb + SW'(1);
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> !regWrite);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regData) |-> regWrite);

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regAddr) |-> regWrite);

  assert_write_after_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> (sinceStb == SW'(NUM_BYTES - 1)));

endmodule

bind byte_cmd_decoder byte_cmd_decoder_chk #(
  .NUM_BYTES (NUM_BYTES),
  .REL_BITS  (REL_BITS),
  .DW        (DW)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdStrobe (cmdStrobe),
  .regWrite  (regWrite),
  .regData   (regData),
  .regAddr   (regAddr)
);

// File: tb/test_byte_cmd_decoder.sv
module test_byte_cmd_decoder;
  localparam logic [15:0] BASE = 16'h0300;
  localparam logic [15:0] MASK = 16'h03FE;

  // {address, data}
  localparam logic [47:0] VEC [0:7] = '{
    {16'h0300, 32'h1234_5678},
    {16'h0301, 32'hDEAD_BEEF},
    {16'h0302, 32'hFFFF_0000},
    {16'h0700, 32'hA5A5_5A5A},
    {16'h0200, 32'h0BAD_F00D},
    {16'h03FF, 32'h0000_0001},
    {16'h1301, 32'h8001_00FF},
    {16'h0300, 32'h0102_0304}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic        cmdStrobe = 1'b0;
  logic [0:0]  regAddr;
  logic [31:0] regData;
  logic        regWrite;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  logic [31:0] expData = '0;
  logic        expAddr = 1'b0;

  always #10 clk = ~clk;

  byte_cmd_decoder i_byte_cmd_decoder (
    .clk(clk), .rstN(rstN), .cmdByte(cmdByte), .cmdStrobe(cmdStrobe),
    .regAddr(regAddr), .regData(regData), .regWrite(regWrite)
  );

  always @(negedge clk) if (rstN && regWrite) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic driveByte(input logic [7:0] b, input logic stb);
    @(negedge clk);
    cmdByte   = b;
    cmdStrobe = stb;
  endtask

  task automatic sendBody(input logic [15:0] a, input logic [31:0] d);
    driveByte(a[7:0], 1'b1);
    driveByte(a[15:8], 1'b0);
    for (int i = 0; i < 4; i++) driveByte(d[8*i +: 8], 1'b0);
  endtask

  function automatic logic hit(input logic [15:0] a);
    return (a & MASK) == (BASE & MASK);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 regWrite", 32'(regWrite), 0);
    check("R1 regData", regData, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 regAddr", 32'(regAddr), 0);

    // Vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      logic [15:0] a;
      logic [31:0] d;
      logic        h;
      a = VEC[v][47:32];
      d = VEC[v][31:0];
      h = hit(a);
      sendBody(a, d);
      check("R4 no early write", 32'(regWrite), 0);
      driveByte(8'h00, 1'b0);
      if (h) begin
        expData = d;
        expAddr = a[0];
      end
      check(h ? "R3 R4 write on match" : "R3 R5 no write on miss", 32'(regWrite), 32'(h));
      check(h ? "R2 data packing" : "R5 data held", regData, expData);
      check(h ? "R6 relative address" : "R5 R6 address held", 32'(regAddr), 32'(expAddr));
      @(negedge clk);
      check("R4 single cycle", 32'(regWrite), 0);
    end

    // R7: strobe mid-sequence restarts collection
    p0 = pulses;
    driveByte(8'h00, 1'b1);
    driveByte(8'h03, 1'b0);
    driveByte(8'hAA, 1'b0);
    driveByte(8'hBB, 1'b0);
    sendBody(16'h0301, 32'h1122_3344);
    driveByte(8'h00, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 one write after restart", pulses - p0, 1);
    check("R7 restarted data", regData, 32'h1122_3344);
    check("R7 restarted address", 32'(regAddr), 1);
    expData = 32'h1122_3344; expAddr = 1'b1;

    // R8: unstrobed idle bytes ignored
    p0 = pulses;
    for (int i = 0; i < 12; i++) driveByte(8'(8'h30 + i), 1'b0);
    driveByte(8'h00, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 no write from idle bytes", pulses - p0, 0);
    check("R8 data unchanged", regData, expData);

    // R9: back-to-back commands
    p0 = pulses;
    sendBody(16'h0300, 32'hCAFE_0001);
    sendBody(16'h0301, 32'hCAFE_0002);
    driveByte(8'h00, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 two writes back to back", pulses - p0, 2);
    check("R9 final data", regData, 32'hCAFE_0002);
    check("R9 final address", 32'(regAddr), 1);

    // R1: reset mid-command drops it
    p0 = pulses;
    driveByte(8'h00, 1'b1);
    driveByte(8'h03, 1'b0);
    driveByte(8'h55, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async clear data", regData, 0);
    check("R1 async clear write", 32'(regWrite), 0);
    @(negedge clk);
    rstN = 1'b1;
    cmdByte = 8'h66; cmdStrobe = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", 32'(regWrite), 0);
    driveByte(8'h77, 1'b0);
    driveByte(8'h88, 1'b0);
    driveByte(8'h00, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 R8 dropped command", pulses - p0, 0);
    check("R1 data stays cleared", regData, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule